// File: doc/BRIEF.md
# Back Porch Gate Generator

This block watches an active-low sliced composite sync bit, `csync_n`, and produces an active-low gate, `gate_n`. The gate marks the stretch of each line just after sync ends, where the colour burst can be sampled or the black level clamped. Each trailing (rising) edge of sync starts a fixed wait, and a low gate pulse of fixed width follows it. The wait and the width are given as parameters in clock cycles.

Edges come from every line sync and also from every serration pulse inside the vertical interval, so each of them produces its own gate. If a new edge arrives while a wait or a gate is still running, the block drops what is pending and times afresh from the new edge. The input is registered twice before edge detection, and the gate comes straight from a flip-flop, so the output is free of glitches.

Top module: `bp_gate_gen`

## Requirements
- R1: From reset until the first rising edge of `csync_n` seen after reset, `gate_n` is held high (1). The input history is taken to be high at reset.
- R2: A rising edge is a clock edge at which `csync_n` is sampled 1 while it was sampled 0 at the clock edge before. A falling edge or a steady level never starts a gate.
- R3: `gate_n` goes low exactly `DELAY_CYC`+1 clock cycles after the clock edge that sampled the rising edge. With DELAY_CYC=6 this is 7 cycles.
- R4: When no new edge intervenes, `gate_n` stays low for exactly `WIDTH_CYC` clock cycles and then returns high until the next rising edge.
- R5: A rising edge that arrives while the wait is still running restarts the wait from the new edge. The gate belonging to the earlier edge never appears.
- R6: A rising edge that arrives while the gate is low drives `gate_n` high one cycle after the edge is detected. A full wait and gate then follow from the new edge.
- R7: A sync low of a single clock cycle, and a sync high of a single clock cycle such as a serration pulse, each count as a complete rising edge and each start gate timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| csync_n | input | 1 | Sliced composite sync, low during sync |
| gate_n | output | 1 | Burst/back-porch gate, low while the gate is active |

## Verification
Consider the clock edge at which `csync_n` is first sampled high after being low. The gate is due to fall `DELAY_CYC`+1 cycles after that edge, to rise `WIDTH_CYC` cycles later, and to go high one cycle after a retriggering edge is detected. The bench records the level sampled at every clock edge in a short history. A bench function then finds the most recent edge that is old enough to have taken effect, and from its age it gives the expected gate level. The output is compared once per cycle on the falling clock edge, midway between two updates. This way every due cycle, and every cycle next to one, is checked in every scenario.

// File: rtl/bpg_pkg.sv
package bpg_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_GATE = 2'd2
    } phase_e;

    typedef struct packed {
        logic in_q;
        logic prev_q;
    } edge_s;

endpackage

// File: rtl/bpg_edge_det.sv
module bpg_edge_det
    import bpg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_n,
    output logic rise
);

    edge_s st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.in_q   = sync_n;
        st_d.prev_q = st_q.in_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{in_q: 1'b1, prev_q: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    // Trailing edge of sync: sampled low then high on consecutive clocks
    assign rise = st_q.in_q & ~st_q.prev_q;

endmodule

// File: rtl/bpg_sequencer.sv
module bpg_sequencer
    import bpg_pkg::*;
#(
    parameter int DELAY_CYC = 25,
    parameter int WIDTH_CYC = 438
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    output logic gate_n
);

    localparam int MAX_CYC = (DELAY_CYC > WIDTH_CYC) ? DELAY_CYC : WIDTH_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DELAY_CYC - 1);
    localparam logic [CNT_W-1:0] WID_LAST = CNT_W'(WIDTH_CYC - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             gate_n;
    } seq_s;

    seq_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rise) begin
            st_d.phase = PH_WAIT;
            st_d.cnt   = '0;
        end else begin
            unique case (st_q.phase)
                PH_WAIT: begin
                    if (st_q.cnt == DLY_LAST) begin
                        st_d.phase = PH_GATE;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                PH_GATE: begin
                    if (st_q.cnt == WID_LAST) begin
                        st_d.phase = PH_IDLE;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: begin
                    st_d.phase = PH_IDLE;
                    st_d.cnt   = '0;
                end
            endcase
        end
        st_d.gate_n = (st_d.phase != PH_GATE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, gate_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_n = st_q.gate_n;

endmodule

// File: rtl/bp_gate_gen.sv
module bp_gate_gen #(
    parameter int DELAY_CYC = 25,
    parameter int WIDTH_CYC = 438
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csync_n,
    output logic gate_n
);

    logic rise;

    bpg_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_n (csync_n),
        .rise   (rise)
    );

    bpg_sequencer #(
        .DELAY_CYC (DELAY_CYC),
        .WIDTH_CYC (WIDTH_CYC)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise   (rise),
        .gate_n (gate_n)
    );

endmodule

// File: rtl/bpg_checker.sv
module bpg_checker #(
    parameter int DELAY_CYC = 25,
    parameter int WIDTH_CYC = 438
) (
    input logic clk,
    input logic rst_n,
    input logic csync_n,
    input logic gate_n
);

    localparam int SAT   = DELAY_CYC + WIDTH_CYC + 2;
    localparam int AGE_W = $clog2(SAT + 1);
    localparam logic [AGE_W-1:0] AGE_LO  = AGE_W'(DELAY_CYC + 1);
    localparam logic [AGE_W-1:0] AGE_HI  = AGE_W'(DELAY_CYC + WIDTH_CYC);
    localparam logic [AGE_W-1:0] AGE_END = AGE_W'(DELAY_CYC + WIDTH_CYC + 1);
    localparam logic [AGE_W-1:0] AGE_SAT = AGE_W'(SAT);

    logic             s1_q, s2_q;
    logic [AGE_W-1:0] age_q;
    logic             seen_rise;

    assign seen_rise = s1_q & ~s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q  <= 1'b1;
            s2_q  <= 1'b1;
            age_q <= AGE_SAT;
        end else begin
            s1_q <= csync_n;
            s2_q <= s1_q;
            if (seen_rise)           age_q <= AGE_W'(1);
            else if (age_q != AGE_SAT) age_q <= age_q + 1'b1;
        end
    end

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> gate_n); // R1

    AST_GATE_ONLY_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_n |-> (age_q >= AGE_LO && age_q <= AGE_HI)); // R2

    AST_GATE_STARTS_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == AGE_LO) |-> !gate_n); // R3

    AST_GATE_ENDS_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == AGE_END) |-> gate_n); // R4

    AST_WAIT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rise && gate_n) |=> gate_n); // R5

    AST_RETRIG_ENDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rise && !gate_n) |=> gate_n); // R6

endmodule

bind bp_gate_gen bpg_checker #(
    .DELAY_CYC (DELAY_CYC),
    .WIDTH_CYC (WIDTH_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .csync_n (csync_n),
    .gate_n  (gate_n)
);

// File: tb/sim_bp_gate_gen.sv
`timescale 1ns/1ps
module sim_bp_gate_gen;

    localparam int D = 6;
    localparam int W = 20;
    localparam int HIST = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csync_n = 1'b1;
    logic gate_n;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic hist [HIST];

    always #4 clk = ~clk;

    bp_gate_gen #(.DELAY_CYC(D), .WIDTH_CYC(W)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .csync_n (csync_n),
        .gate_n  (gate_n)
    );

    function automatic logic hget(int idx);
        if (idx < 0) return 1'b1;
        return hist[idx % HIST];
    endfunction

    // Expected gate level after clock edge n: newest edge r <= n-1 rules
    function automatic logic exp_gate(int n);
        for (int k = 1; k <= D + W + 1; k++) begin
            int r;
            r = n - k;
            if (r < 1) return 1'b1;
            if (hget(r) && !hget(r - 1))
                return !(k >= D + 1 && k <= D + W);
        end
        return 1'b1;
    endfunction

    task automatic drive(input logic v, input int len, input string tag);
        for (int i = 0; i < len; i++) begin
            csync_n = v;
            @(posedge clk);
            cyc++;
            hist[cyc % HIST] = v;
            @(negedge clk);
            checks++;
            if (gate_n !== exp_gate(cyc)) begin
                failures++;
                $display("FAIL %s cycle %0d gate_n actual=%b expected=%b",
                         tag, cyc, gate_n, exp_gate(cyc));
            end
        end
    endtask

    initial begin
        for (int i = 0; i < HIST; i++) hist[i] = 1'b1;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        checks++;
        if (gate_n !== 1'b1) begin
            failures++;
            $display("FAIL R1 in reset gate_n actual=%b expected=1", gate_n);
        end
        rst_n = 1'b1;
        drive(1'b1, 12, "R1");
        drive(1'b0, 15, "R2");
        drive(1'b1, 60, "R3");
        drive(1'b0, 20, "R2");
        drive(1'b1, 60, "R4");
        // edge during the wait
        drive(1'b0, 5, "R5");
        drive(1'b1, 3, "R5");
        drive(1'b0, 2, "R5");
        drive(1'b1, 60, "R5");
        // edge during the gate
        drive(1'b0, 5, "R6");
        drive(1'b1, 12, "R6");
        drive(1'b0, 3, "R6");
        drive(1'b1, 60, "R6");
        // single-cycle low, then a single-cycle serration-like high
        drive(1'b0, 1, "R7");
        drive(1'b1, 40, "R7");
        drive(1'b0, 20, "R7");
        drive(1'b1, 1, "R7");
        drive(1'b0, 20, "R7");
        drive(1'b1, 40, "R7");
        // constrained random segments
        for (int s = 0; s < 400; s++) begin
            int len;
            len = 1 + int'($urandom % 40);
            drive(s[0], len, "R2");
        end
        drive(1'b1, 40, "R4");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule